// File: doc/BRIEF.md
# DMA Channel Interrupt and Loop Control Register Block

This block is the shared control register bank of a sixteen-channel DMA engine. The channel engines report finished work as one-cycle pulses. The block latches each pulse into a per-channel status bit and combines the enabled status bits into one registered interrupt line. Software reaches the bank over a plain 32-bit register bus. Each write is a single-cycle strobe, and each read returns its data on the cycle after the read strobe.

The enable and loop registers each have a second, clear-only address. A driver can therefore drop single bits without a read-modify-write sequence that could race with another agent. Status bits are cleared by writing ones to them. Looping on channel n needs both bit n and bit n+16 of the loop register to be set. Clearing those bits pauses a looping channel. A write-one strobe register sends a one-cycle abort pulse to each selected channel.

The interrupt line is driven by a two-state machine:
- IRQ_IDLE takes the raise transition to IRQ_ACTIVE when any status bit is set together with its enable bit.
- IRQ_ACTIVE takes the drop transition back to IRQ_IDLE once no enabled status bit remains.
- Each state otherwise holds.

Top module: `dmaic_top`

## Requirements
- R1: After reset, status, enable and loop registers are zero, `irq` is low, `chan_abort` is zero and `loop_active` is zero.
- R2: A pulse on `chan_done[n]` sets status bit n on that clock edge. The status register reads at byte offset 0x144, bit n for channel n in bits 0..15.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and bits 16..31 of the written data are ignored.
- R4: When `chan_done[n]` and a write-one-clear of status bit n fall in the same cycle, the bit stays set.
- R5: The enable register at 0x148 is read/write in bits 0..15 and reads 0 in bits 16..31. Writing ones to 0x14C clears the matching enable bits, and 0x14C reads as zero.
- R6: The loop register at 0x150 is 32-bit read/write and appears on `loop_ctrl`. Writing ones to 0x154 clears the matching loop bits, and 0x154 reads as zero.
- R7: `loop_active[n]` is high only while loop bits n and n+16 are both set.
- R8: Writing bit n = 1 at 0x140 drives `chan_abort[n]` high for exactly the one cycle after the write edge. 0x140 reads as zero.
- R9: `irq` rises one clock after any status bit is set with its enable bit, and it falls one clock after no such bit remains.
- R10: `bus_rdata` is registered and is valid from the edge that samples `bus_rd`. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| chan_done | input | NCH | Per-channel completion pulses |
| chan_abort | output | NCH | Per-channel one-cycle abort pulses |
| loop_ctrl | output | 2*NCH | Raw loop register contents |
| loop_active | output | NCH | Channel n loop enable (both of its bits set) |
| irq | output | 1 | Combined registered interrupt |

## Verification
A completion pulse from a channel engine and a software write-one-clear of the same status bit can arrive in the same cycle. The bench provokes this by raising `chan_done` on the very cycle that the status write strobe is driven, and then reads the register back. The bench judges the result correct only if the bit is still set. The same pairing is also checked against the interrupt line: an event on a disabled channel must leave `irq` low, and a later enable write must raise it one cycle after the enable bit is set.

// File: rtl/dmaic_pkg.sv
package dmaic_pkg;

    // Byte offsets of the register bank
    localparam logic [11:0] OFS_ABORT    = 12'h140;
    localparam logic [11:0] OFS_STATUS   = 12'h144;
    localparam logic [11:0] OFS_ENABLE   = 12'h148;
    localparam logic [11:0] OFS_EN_CLR   = 12'h14C;
    localparam logic [11:0] OFS_LOOP     = 12'h150;
    localparam logic [11:0] OFS_LOOP_CLR = 12'h154;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/dmaic_stat_reg.sv
module dmaic_stat_reg #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] q
);

    // One sticky bit per channel; a same-cycle event overrides the clear.
    for (genvar n = 0; n < NCH; n++) begin : g_bit
        logic bit_q;
        logic bit_d;

        always_comb begin
            bit_d = bit_q;
            if (clr_we && clr_mask[n]) begin
                bit_d = 1'b0;
            end
            if (evt[n]) begin
                bit_d = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= bit_d;
            end
        end

        assign q[n] = bit_q;
    end

endmodule

// File: rtl/dmaic_setclr_reg.sv
module dmaic_setclr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_we,
    input  logic [W-1:0] wr_val,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    logic [W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_we) begin
            reg_q <= wr_val;
        end else if (clr_we) begin
            reg_q <= reg_q & ~clr_mask;
        end
    end

    assign q = reg_q;

endmodule

// File: rtl/dmaic_irq_fsm.sv
module dmaic_irq_fsm
    import dmaic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE;  // raise
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;    // drop
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmaic_top.sv
module dmaic_top
    import dmaic_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    chan_done,
    output logic [NCH-1:0]    chan_abort,
    output logic [2*NCH-1:0]  loop_ctrl,
    output logic [NCH-1:0]    loop_active,
    output logic              irq
);

    localparam int LW = 2 * NCH;

    logic hit_abort, hit_status, hit_enable, hit_en_clr, hit_loop, hit_loop_clr;
    logic [NCH-1:0]    stat_q;
    logic [NCH-1:0]    en_q;
    logic [LW-1:0]     loop_q;
    logic [NCH-1:0]    abort_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // Write decode
    always_comb begin
        hit_abort    = bus_wr && (bus_addr == ADDR_W'(OFS_ABORT));
        hit_status   = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
        hit_enable   = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
        hit_en_clr   = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
        hit_loop     = bus_wr && (bus_addr == ADDR_W'(OFS_LOOP));
        hit_loop_clr = bus_wr && (bus_addr == ADDR_W'(OFS_LOOP_CLR));
    end

    dmaic_stat_reg #(.NCH(NCH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (chan_done),
        .clr_we   (hit_status),
        .clr_mask (bus_wdata[NCH-1:0]),
        .q        (stat_q)
    );

    dmaic_setclr_reg #(.W(NCH)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_we    (hit_enable),
        .wr_val   (bus_wdata[NCH-1:0]),
        .clr_we   (hit_en_clr),
        .clr_mask (bus_wdata[NCH-1:0]),
        .q        (en_q)
    );

    dmaic_setclr_reg #(.W(LW)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_we    (hit_loop),
        .wr_val   (bus_wdata[LW-1:0]),
        .clr_we   (hit_loop_clr),
        .clr_mask (bus_wdata[LW-1:0]),
        .q        (loop_q)
    );

    dmaic_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(stat_q & en_q)),
        .irq     (irq)
    );

    // Abort strobe: one-cycle pulse, nothing stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= '0;
        end else if (hit_abort) begin
            abort_q <= bus_wdata[NCH-1:0];
        end else begin
            abort_q <= '0;
        end
    end

    // Per-channel loop enable needs both of its bits
    for (genvar n = 0; n < NCH; n++) begin : g_loop
        assign loop_active[n] = loop_q[n] & loop_q[n+NCH];
    end

    // Read path
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            rd_mux = DATA_W'(stat_q);
        end else if (bus_addr == ADDR_W'(OFS_ENABLE)) begin
            rd_mux = DATA_W'(en_q);
        end else if (bus_addr == ADDR_W'(OFS_LOOP)) begin
            rd_mux = DATA_W'(loop_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign chan_abort = abort_q;
    assign loop_ctrl  = loop_q;

endmodule

// File: rtl/dmaic_chk.sv
module dmaic_chk
    import dmaic_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    chan_done,
    input logic [NCH-1:0]    chan_abort,
    input logic [NCH-1:0]    loop_active,
    input logic [NCH-1:0]    stat_q,
    input logic [NCH-1:0]    en_q,
    input logic              irq
);

    // R2 R4
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_done != '0) |=> ((stat_q & $past(chan_done)) == $past(chan_done)));

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && chan_done == '0) |=> (stat_q == $past(stat_q)));

    // R5
    enable_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> $past(bus_wr));

    // R7
    loop_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active != $past(loop_active)) |-> $past(bus_wr));

    // R8
    abort_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_abort != '0) |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_ABORT)));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) != '0) |=> irq);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |=> !irq);

endmodule

bind dmaic_top dmaic_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dmaic_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .chan_done   (chan_done),
    .chan_abort  (chan_abort),
    .loop_active (loop_active),
    .stat_q      (stat_q),
    .en_q        (en_q),
    .irq         (irq)
);

// File: tb/tb_dmaic_top.sv
module tb_dmaic_top;

    localparam int NCH = 16;
    localparam logic [11:0] A_ABT = 12'h140, A_ST = 12'h144, A_EN = 12'h148,
                            A_ENC = 12'h14C, A_LP = 12'h150, A_LPC = 12'h154,
                            A_NONE = 12'h000, A_UNM = 12'h3FC;

    typedef struct packed {
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [15:0] ev;
        logic [11:0] raddr;
        logic [31:0] rexp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{A_EN,   32'hABCD00FF, 16'h0000, A_EN,  32'h000000FF}, // R5 upper bits read 0
        '{A_NONE, 32'h0,        16'h0013, A_ST,  32'h00000013}, // R2 events latch
        '{A_ST,   32'h00000001, 16'h0000, A_ST,  32'h00000012}, // R3 w1c
        '{A_ST,   32'h00000002, 16'h0002, A_ST,  32'h00000012}, // R4 event wins
        '{A_ST,   32'h00000000, 16'h0000, A_ST,  32'h00000012}, // R3 zero no effect
        '{A_ENC,  32'h0000000F, 16'h0000, A_EN,  32'h000000F0}, // R5 clear alias
        '{A_LP,   32'h00050005, 16'h0000, A_LP,  32'h00050005}, // R6 loop rw
        '{A_LPC,  32'h00010001, 16'h0000, A_LP,  32'h00040004}, // R6 loop clear
        '{A_ENC,  32'h00000000, 16'h0000, A_ENC, 32'h00000000}, // R5 clear reads 0
        '{A_ST,   32'hFFFFFFFF, 16'h0000, A_ST,  32'h00000000}, // R3 clear all
        '{A_NONE, 32'h0,        16'h0000, A_UNM, 32'h00000000}, // R10 unmapped
        '{A_LP,   32'h00040004, 16'h0000, A_LPC, 32'h00000000}  // R6 clear reads 0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] chan_done = '0;
    logic [NCH-1:0] chan_abort;
    logic [2*NCH-1:0] loop_ctrl;
    logic [NCH-1:0] loop_active;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmaic_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_done(chan_done), .chan_abort(chan_abort), .loop_ctrl(loop_ctrl),
        .loop_active(loop_active), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a negedge; returns just after the next negedge.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input logic [15:0] ev, output logic [15:0] ab);
        bus_wr = (a != A_NONE); bus_addr = a; bus_wdata = d; chan_done = ev;
        @(posedge clk); #1 ab = chan_abort;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; chan_done = '0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic [15:0] ab;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 abort", 32'(chan_abort), 32'h0);
        check("R1 loop_active", 32'(loop_active), 32'h0);
        do_read(A_ST, rd); check("R1 status", rd, 32'h0);
        do_read(A_EN, rd); check("R1 enable", rd, 32'h0);
        do_read(A_LP, rd); check("R1 loop", rd, 32'h0);

        // Vector walk (each entry tagged beside it)
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].waddr, VECS[i].wdata, VECS[i].ev, ab);
            do_read(VECS[i].raddr, rd);
            check($sformatf("vector %0d", i), rd, VECS[i].rexp);
        end

        // R7 loop activity needs both bits
        check("R7 both bits", 32'(loop_active), 32'h0004);
        check("R6 loop_ctrl port", loop_ctrl, 32'h00040004);
        do_write(A_LP, 32'h00000004, 16'h0, ab);
        check("R7 low bit only", 32'(loop_active), 32'h0);
        do_write(A_LP, 32'h00040000, 16'h0, ab);
        check("R7 high bit only", 32'(loop_active), 32'h0);
        do_write(A_LP, 32'h00040004, 16'h0, ab);
        check("R7 restored", 32'(loop_active), 32'h0004);

        // R8 abort pulse
        do_write(A_ABT, 32'hFFFF8001, 16'h0, ab);
        check("R8 pulse", 32'(ab), 32'h8001);
        do_write(A_NONE, 32'h0, 16'h0, ab);
        check("R8 one cycle", 32'(ab), 32'h0);
        do_read(A_ABT, rd); check("R8 reads zero", rd, 32'h0);

        // R9 interrupt timing (enable = 0x00F0)
        do_write(A_NONE, 32'h0, 16'h0010, ab);
        check("R9 not yet", 32'(irq), 32'h0);
        tick();
        check("R9 raised", 32'(irq), 32'h1);
        do_write(A_ST, 32'h00000010, 16'h0, ab);
        check("R9 lag on clear", 32'(irq), 32'h1);
        tick();
        check("R9 dropped", 32'(irq), 32'h0);
        do_write(A_NONE, 32'h0, 16'h0100, ab);
        tick();
        check("R9 disabled event", 32'(irq), 32'h0);
        do_write(A_EN, 32'h00000100, 16'h0, ab);
        check("R9 enable lag", 32'(irq), 32'h0);
        tick();
        check("R9 enable raises", 32'(irq), 32'h1);
        // R4 collision seen at irq
        do_write(A_ST, 32'h00000100, 16'h0100, ab);
        tick();
        check("R4 irq stays", 32'(irq), 32'h1);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule